// File: doc/BRIEF.md
# Bus Error Timeout Generator

This block supervises local bus cycles started by a processor or a DMA engine and ends any cycle that hangs by pulling an active-low local bus error strobe. A cycle is open while the address strobe is low. Address decoding happens elsewhere and arrives as region-hit strobes. One timer covers the onboard regions (main memory, user ROM, local I/O) and has a fixed limit. A second timer covers the expansion regions (secondary or VSB-style buses). Its limit is picked by a two-bit field in an 8-bit control register, or the timer is switched off. A third timer covers accesses that go out to the system backplane.

The block also drives an active-low bus error toward the backplane. Three conditions pull it low: a broadcast message rejected because the message queue is full, a parity error that the enables qualify, and expiry of the backplane access timer. A 1 us tick comes from the system clock through a prescaler. The prescaler and all timers clear whenever the address strobe is high, so each cycle gets a full, exact window.

Top module: `berr_timeout_gen`

## Requirements
- R1: After reset both `berr_loc_n` and `berr_bp_n` are high and `reg_rdata` reads 0x00, which means the expansion timer is off.
- R2: The onboard timer starts when `as_n` is low and, in the same cycle, a processor cycle (`dma_cyc`=0) hits main memory, user ROM or local I/O, or a DMA cycle (`dma_cyc`=1) hits main memory. A DMA cycle that hits only ROM or local I/O starts no timer.
- R3: With `as_n` held low, `berr_loc_n` stays high through clock edge ONB_US*CLK_PER_US-1, counted from the first edge at which the cycle is sampled. It goes low after edge ONB_US*CLK_PER_US.
- R4: If `as_n` returns high before a limit is reached, no bus error is raised. The next cycle then gets a full window again.
- R5: Once `berr_loc_n` is low it stays low while `as_n` is low. It goes high after the first edge at which `as_n` is sampled high.
- R6: The expansion timer starts on `hit_exp` from either master. Its limit comes from control bits 7:6: 00 = off (no error ever), 01 = EXP_SHORT_US, 10 = EXP_MID_US, 11 = EXP_LONG_US, each in microseconds.
- R7: A write with `reg_wr`=1 stores `reg_wdata[7:6]`, which becomes readable on `reg_rdata` from the next cycle. Bits 5:0 are dropped and always read 0.
- R8: `msg_reject`=1 pulls `berr_bp_n` low in the same cycle, with no effect on `berr_loc_n`.
- R9: `par_err` pulls `berr_bp_n` low in the same cycle only while `shm_en`=1 and at least one of `par_opt_a` or `par_opt_b` is 1. Otherwise it has no effect.
- R10: A cycle hitting the backplane (`hit_bp`) that stays open for BP_US*CLK_PER_US edges pulls both `berr_bp_n` and `berr_loc_n` low. Both are held until `as_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, low while a cycle is open |
| dma_cyc | input | 1 | Current cycle is issued by the DMA engine |
| hit_main | input | 1 | Decode hit: main memory |
| hit_rom | input | 1 | Decode hit: user ROM |
| hit_lio | input | 1 | Decode hit: local I/O |
| hit_exp | input | 1 | Decode hit: secondary / expansion bus |
| hit_bp | input | 1 | Decode hit: system backplane |
| msg_reject | input | 1 | Broadcast message refused, queue full |
| par_err | input | 1 | Parity error on backplane access to local memory |
| shm_en | input | 1 | Shared-memory mode enabled |
| par_opt_a | input | 1 | Parity error handling option A enabled |
| par_opt_b | input | 1 | Parity error handling option B enabled |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| berr_loc_n | output | 1 | Local bus error to processor / DMA, active low |
| berr_bp_n | output | 1 | Backplane bus error, active low |

## Verification
The bench builds the block with CLK_PER_US=2, ONB_US=16, EXP_SHORT_US=16, EXP_MID_US=40, EXP_LONG_US=90 and BP_US=32. With these values every expansion select code, including the longest one, expires within a few hundred cycles, so each limit can be checked on the exact edge where the error appears. The small prescaler still divides by more than one, which exercises the tick alignment at the start of a cycle.

// File: rtl/berr_pkg.sv
package berr_pkg;

    // Expansion timeout select, control register bits 7:6
    typedef enum logic [1:0] {
        EXP_OFF   = 2'b00,
        EXP_SHORT = 2'b01,
        EXP_MID   = 2'b10,
        EXP_LONG  = 2'b11
    } exp_sel_e;

    typedef struct packed {
        logic main;
        logic rom;
        logic lio;
        logic exp;
        logic bp;
    } region_hit_t;

    localparam int NUM_TMR = 3;
    localparam int TMR_ONB = 0;
    localparam int TMR_EXP = 1;
    localparam int TMR_BP  = 2;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Onboard timer start: processor to any onboard region, DMA to main memory only
    function automatic logic onb_start(input region_hit_t h, input logic dma);
        return h.main | (~dma & (h.rom | h.lio));
    endfunction

    // Backplane error sources other than the access timer
    function automatic logic par_qualified(input logic perr, input logic shm,
                                           input logic opt_a, input logic opt_b);
        return perr & shm & (opt_a | opt_b);
    endfunction

endpackage

// File: rtl/berr_tick_gen.sv
module berr_tick_gen #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic tick
);
    localparam int PRE_W = $clog2(CLK_PER_US + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = active && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/berr_cycle_timer.sv
module berr_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            expired <= 1'b0;
        end else begin
            if (start) begin
                run_q <= 1'b1;
            end
            // a zero limit means the timer is switched off
            if ((run_q || start) && tick && (limit != '0) && !expired) begin
                if (cnt_nxt == limit) begin
                    expired <= 1'b1;
                end else begin
                    cnt_q <= cnt_nxt;
                end
            end
        end
    end
endmodule

// File: rtl/berr_ctl_reg.sv
module berr_ctl_reg
    import berr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output exp_sel_e   exp_sel
);
    logic [1:0] sel_q;
    logic       unused_wbits;

    assign unused_wbits = ^wdata[5:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 2'b00;
        end else if (wr) begin
            sel_q <= wdata[7:6];
        end
    end

    assign rdata   = {sel_q, 6'b000000};
    assign exp_sel = exp_sel_e'(sel_q);
endmodule

// File: rtl/berr_timeout_gen.sv
module berr_timeout_gen
    import berr_pkg::*;
#(
    parameter int CLK_PER_US   = 125,
    parameter int ONB_US       = 16,
    parameter int EXP_SHORT_US = 16,
    parameter int EXP_MID_US   = 1000,
    parameter int EXP_LONG_US  = 64000,
    parameter int BP_US        = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       as_n,
    input  logic       dma_cyc,
    input  logic       hit_main,
    input  logic       hit_rom,
    input  logic       hit_lio,
    input  logic       hit_exp,
    input  logic       hit_bp,
    input  logic       msg_reject,
    input  logic       par_err,
    input  logic       shm_en,
    input  logic       par_opt_a,
    input  logic       par_opt_b,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       berr_loc_n,
    output logic       berr_bp_n
);
    localparam int LIM_MAX = max_of(max_of(ONB_US, BP_US),
                                    max_of(EXP_SHORT_US, max_of(EXP_MID_US, EXP_LONG_US)));
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    logic        cyc_active;
    logic        tick;
    exp_sel_e    exp_sel;
    region_hit_t hits;
    logic [CNT_W-1:0] exp_limit;
    logic [CNT_W-1:0] lim_arr   [NUM_TMR];
    logic             start_arr [NUM_TMR];
    logic             exp_arr   [NUM_TMR];

    assign cyc_active = ~as_n;
    assign hits = '{main: hit_main, rom: hit_rom, lio: hit_lio, exp: hit_exp, bp: hit_bp};

    berr_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .exp_sel (exp_sel)
    );

    berr_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .active (cyc_active),
        .tick   (tick)
    );

    always_comb begin
        unique case (exp_sel)
            EXP_SHORT: exp_limit = CNT_W'(EXP_SHORT_US);
            EXP_MID:   exp_limit = CNT_W'(EXP_MID_US);
            EXP_LONG:  exp_limit = CNT_W'(EXP_LONG_US);
            default:   exp_limit = '0;
        endcase
    end

    assign lim_arr[TMR_ONB]   = CNT_W'(ONB_US);
    assign lim_arr[TMR_EXP]   = exp_limit;
    assign lim_arr[TMR_BP]    = CNT_W'(BP_US);
    assign start_arr[TMR_ONB] = onb_start(hits, dma_cyc);
    assign start_arr[TMR_EXP] = hits.exp;
    assign start_arr[TMR_BP]  = hits.bp;

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
        berr_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .active  (cyc_active),
            .start   (start_arr[gi]),
            .tick    (tick),
            .limit   (lim_arr[gi]),
            .expired (exp_arr[gi])
        );
    end

    assign berr_loc_n = ~(exp_arr[TMR_ONB] | exp_arr[TMR_EXP] | exp_arr[TMR_BP]);
    assign berr_bp_n  = ~(msg_reject
                          | par_qualified(par_err, shm_en, par_opt_a, par_opt_b)
                          | exp_arr[TMR_BP]);
endmodule

// File: rtl/berr_timeout_gen_chk.sv
module berr_timeout_gen_chk
    import berr_pkg::*;
#(
    parameter int CLK_PER_US   = 125,
    parameter int ONB_US       = 16,
    parameter int EXP_SHORT_US = 16,
    parameter int EXP_MID_US   = 1000,
    parameter int EXP_LONG_US  = 64000,
    parameter int BP_US        = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       as_n,
    input logic       msg_reject,
    input logic       par_err,
    input logic       shm_en,
    input logic       par_opt_a,
    input logic       par_opt_b,
    input logic [7:0] reg_rdata,
    input logic       berr_loc_n,
    input logic       berr_bp_n
);
    localparam int MIN_US  = min_of(min_of(ONB_US, BP_US),
                                    min_of(EXP_SHORT_US, min_of(EXP_MID_US, EXP_LONG_US)));
    localparam int MIN_CYC = MIN_US * CLK_PER_US;
    localparam int BP_CYC  = BP_US * CLK_PER_US;

    int low_cnt;

    always_ff @(posedge clk) begin
        if (rst || as_n) begin
            low_cnt <= 0;
        end else if (low_cnt < BP_CYC + MIN_CYC + 1) begin
            low_cnt <= low_cnt + 1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata == 8'h00 && berr_loc_n)); // R1

    AST_NO_EARLY_ERR: assert property (@(posedge clk) disable iff (rst)
        !berr_loc_n |-> (low_cnt >= MIN_CYC)); // R3

    AST_NORMAL_END: assert property (@(posedge clk) disable iff (rst)
        $past(as_n) |-> berr_loc_n); // R4

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(as_n) && !$past(berr_loc_n)) |-> !berr_loc_n); // R5

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[5:0] == 6'd0)); // R7

    AST_MSG_REJECT: assert property (@(posedge clk) disable iff (rst)
        msg_reject |-> !berr_bp_n); // R8

    AST_PAR_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (!msg_reject && !(shm_en && (par_opt_a || par_opt_b)) && $past(as_n)) |-> berr_bp_n); // R9

    AST_BP_TIMER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!berr_bp_n && !msg_reject && !(par_err && shm_en && (par_opt_a || par_opt_b)))
            |-> (low_cnt >= BP_CYC && !berr_loc_n)); // R10
endmodule

bind berr_timeout_gen berr_timeout_gen_chk #(
    .CLK_PER_US   (CLK_PER_US),
    .ONB_US       (ONB_US),
    .EXP_SHORT_US (EXP_SHORT_US),
    .EXP_MID_US   (EXP_MID_US),
    .EXP_LONG_US  (EXP_LONG_US),
    .BP_US        (BP_US)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .as_n       (as_n),
    .msg_reject (msg_reject),
    .par_err    (par_err),
    .shm_en     (shm_en),
    .par_opt_a  (par_opt_a),
    .par_opt_b  (par_opt_b),
    .reg_rdata  (reg_rdata),
    .berr_loc_n (berr_loc_n),
    .berr_bp_n  (berr_bp_n)
);

// File: tb/test_berr_timeout_gen.sv
`timescale 1ns/1ps
module test_berr_timeout_gen;
    localparam int P       = 2;
    localparam int ONB     = 16;
    localparam int EXP_S   = 16;
    localparam int EXP_M   = 40;
    localparam int EXP_L   = 90;
    localparam int BPL     = 32;

    localparam int K_LOC = 0;
    localparam int K_BP  = 1;
    localparam int K_RD  = 2;

    typedef struct {
        int         at;
        int         kind;
        logic [7:0] val;
        string      req;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, dma_cyc = 1'b0;
    logic hit_main = 0, hit_rom = 0, hit_lio = 0, hit_exp = 0, hit_bp = 0;
    logic msg_reject = 0, par_err = 0, shm_en = 0, par_opt_a = 0, par_opt_b = 0;
    logic reg_wr = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic berr_loc_n, berr_bp_n;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    sb_item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    berr_timeout_gen #(
        .CLK_PER_US(P), .ONB_US(ONB), .EXP_SHORT_US(EXP_S),
        .EXP_MID_US(EXP_M), .EXP_LONG_US(EXP_L), .BP_US(BPL)
    ) i_berr_timeout_gen (
        .clk(clk), .rst(rst), .as_n(as_n), .dma_cyc(dma_cyc),
        .hit_main(hit_main), .hit_rom(hit_rom), .hit_lio(hit_lio),
        .hit_exp(hit_exp), .hit_bp(hit_bp), .msg_reject(msg_reject),
        .par_err(par_err), .shm_en(shm_en), .par_opt_a(par_opt_a),
        .par_opt_b(par_opt_b), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .berr_loc_n(berr_loc_n), .berr_bp_n(berr_bp_n)
    );

    // monitor: compare scoreboard items at the falling edge of their cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_LOC:   act = {7'd0, berr_loc_n};
                K_BP:    act = {7'd0, berr_bp_n};
                default: act = reg_rdata;
            endcase
            n_checks++;
            if (it.at != cyc) begin
                n_fail++;
                $display("FAIL %s item for cycle %0d missed at cycle %0d", it.req, it.at, cyc);
            end else if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s cycle %0d kind %0d actual %h expected %h",
                         it.req, cyc, it.kind, act, it.val);
            end
        end
    end

    task automatic push(input int at, input int kind, input logic [7:0] v, input string req);
        sb_item_t it;
        it.at = at; it.kind = kind; it.val = v; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) step();
    endtask

    task automatic set_hits(input logic [4:0] h);
        {hit_main, hit_rom, hit_lio, hit_exp, hit_bp} = h;
    endtask

    // One bus cycle. lim = expected expiry in edges (0 = none), hold = extra edges held.
    task automatic bus_cycle(input logic [4:0] h, input logic dma, input int lim,
                             input int hold, input bit bp_too, input string req);
        int n, m;
        n = cyc;
        set_hits(h);
        dma_cyc = dma;
        as_n = 1'b0;
        if (lim > 0) begin
            push(n + lim - 1, K_LOC, 8'h01, req);
            if (bp_too) push(n + lim - 1, K_BP, 8'h01, req);
            push(n + lim, K_LOC, 8'h00, req);
            if (bp_too) push(n + lim, K_BP, 8'h00, req);
            m = n + lim + hold;
            push(m, K_LOC, 8'h00, "R5");
            if (bp_too) push(m, K_BP, 8'h00, "R10");
        end else begin
            m = n + hold;
            push(m, K_LOC, 8'h01, req);
            push(m, K_BP, 8'h01, req);
        end
        push(m + 1, K_LOC, 8'h01, "R5");
        push(m + 1, K_BP, 8'h01, "R5");
        wait_to(m);
        as_n = 1'b1;
        set_hits(5'b0);
        dma_cyc = 1'b0;
        wait_to(m + 3);
    endtask

    task automatic reg_write(input logic [7:0] v);
        int n;
        n = cyc;
        reg_wr = 1'b1;
        reg_wdata = v;
        push(n + 1, K_RD, v & 8'hC0, "R7");
        step();
        reg_wr = 1'b0;
        wait_to(n + 2);
    endtask

    task automatic comb_bp(input logic mr, input logic pe, input logic sh,
                           input logic oa, input logic ob, input logic exp_n, input string req);
        int n;
        n = cyc;
        msg_reject = mr; par_err = pe; shm_en = sh; par_opt_a = oa; par_opt_b = ob;
        push(n, K_BP, {7'd0, exp_n}, req);
        push(n, K_LOC, 8'h01, req);
        step();
        msg_reject = 0; par_err = 0; shm_en = 0; par_opt_a = 0; par_opt_b = 0;
        step();
    endtask

    // watchdog
    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // driver
    initial begin
        repeat (3) step();
        rst = 1'b0;
        push(cyc, K_RD, 8'h00, "R1");
        push(cyc, K_LOC, 8'h01, "R1");
        push(cyc, K_BP, 8'h01, "R1");
        step(); step();

        // onboard timer: {main,rom,lio,exp,bp}
        bus_cycle(5'b10000, 1'b0, ONB * P, 3, 1'b0, "R3");  // R2 processor main
        bus_cycle(5'b01000, 1'b0, ONB * P, 1, 1'b0, "R2");  // processor ROM
        bus_cycle(5'b00100, 1'b0, ONB * P, 2, 1'b0, "R2");  // processor local I/O
        bus_cycle(5'b10000, 1'b1, ONB * P, 1, 1'b0, "R2");  // DMA main
        bus_cycle(5'b01100, 1'b1, 0, ONB * P + 8, 1'b0, "R2"); // DMA ROM/IO: no timer
        // normal end then a fresh full window
        bus_cycle(5'b10000, 1'b0, 0, ONB * P - 4, 1'b0, "R4");
        bus_cycle(5'b10000, 1'b0, ONB * P, 1, 1'b0, "R4");

        // expansion: off by default
        bus_cycle(5'b00010, 1'b0, 0, EXP_L * P + 10, 1'b0, "R6");
        reg_write(8'h7F);                                    // R7 masks low bits, selects 01
        bus_cycle(5'b00010, 1'b1, EXP_S * P, 2, 1'b0, "R6");
        reg_write(8'hBF);
        bus_cycle(5'b00010, 1'b0, EXP_M * P, 1, 1'b0, "R6");
        reg_write(8'hC0);
        bus_cycle(5'b00010, 1'b0, EXP_L * P, 2, 1'b0, "R6");
        reg_write(8'h3F);                                    // back to off
        bus_cycle(5'b00010, 1'b1, 0, EXP_M * P + 4, 1'b0, "R6");

        // backplane sources
        comb_bp(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        comb_bp(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
        comb_bp(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        comb_bp(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
        comb_bp(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
        comb_bp(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        bus_cycle(5'b00001, 1'b0, BPL * P, 3, 1'b1, "R10");
        bus_cycle(5'b00001, 1'b1, 0, BPL * P - 2, 1'b0, "R10");

        repeat (4) step();
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule